// File: doc/BRIEF.md
# Byte-Swapping IDE Register Bridge

This block sits between a big-endian host memory bus and the register port of an IDE drive. The host sees a 4 KB window. Within that window the drive registers are laid out on a 16-byte pitch. Each access carries a size code of byte, half-word or word. The bridge turns the window offset into a register index and checks that index against the access size. It then either forwards the access as one downstream register strobe or drops it.

Byte-wide accesses reach the seven task-file registers. They also reach the device-control register, which two aliased indices lead to. A read at either alias returns the alternate status. Half-word and word accesses reach only the data register, and the bridge reverses their byte lanes in both directions so that the little-endian drive data appears in host order. Any access that fails to decode produces no strobe. If it is a read, it returns all ones at its own width.

Downstream read data is taken in the cycle of the request. It is registered and returned with a one-cycle valid pulse. Writes return nothing.

Top module: `ide_mmio_bridge`

## Requirements
- R1: The register index is bits [11:4] of the request address. Address bits [3:0] and all bits above bit 11 have no effect on decoding.
- R2: A byte access (size code 0) at index 1..7 strobes the downstream port once, with `reg_index` equal to the index. A write carries the host byte in `reg_wdata[7:0]` with zeros above it. A read returns `reg_rdata[7:0]` zero-extended to 32 bits.
- R3: A byte access at index 8 or index 22 strobes the downstream port with `reg_index` = 8, the control port. A write there goes to device control, and a read returns the alternate status that the drive presents on `reg_rdata[7:0]`.
- R4: A byte access at any other index, index 0 included, produces no strobe. A read there returns 0x000000FF.
- R5: A half-word access (size code 1) at index 0 strobes `reg_index` = 0 once with `reg_size` = 1. The two bytes are swapped on the way down (`reg_wdata[15:0]` = {wdata[7:0], wdata[15:8]}, upper half zero) and on the way up (response {16'h0, rdata[7:0], rdata[15:8]}).
- R6: A word access (size code 2) at index 0 strobes `reg_index` = 0 once with `reg_size` = 2. All four bytes are reversed in both directions.
- R7: A half-word or word access at any index other than 0 produces no strobe. A read there returns 0x0000FFFF for a half-word and 0xFFFFFFFF for a word. The reserved size code 3 never strobes and reads return 0xFFFFFFFF.
- R8: Every read yields `rsp_valid` high for exactly the one cycle after the request cycle. A write yields no `rsp_valid`.
- R9: After reset `rsp_valid` is low and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Host byte address |
| req_wdata | input | 32 | Host write data, right-aligned |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data in host byte order |
| reg_strobe | output | 1 | Downstream register access this cycle |
| reg_write | output | 1 | Downstream direction |
| reg_index | output | 4 | 0 data, 1..7 task file, 8 control/alternate status |
| reg_size | output | 2 | Access size passed to the data register |
| reg_wdata | output | 32 | Downstream write data in drive byte order |
| reg_rdata | input | 32 | Downstream read data, valid in the strobe cycle |

## Verification
A decode fault shows at the ports in the request cycle itself. A strobe appears on a dropped access, is missing on a mapped one, or carries the wrong `reg_index`, and the bench catches it by sampling the downstream outputs within that cycle. A lane-order fault or a wrong unmapped fill shows one cycle later as a wrong `rsp_rdata` beside `rsp_valid`. Each access has a distinct expected data pattern, so one wrong byte lane is enough to show the fault. A fault in the response register shows as a missing, doubled or unrequested `rsp_valid` pulse. The scoreboard looks for that pulse on every cycle, idle cycles included.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_DATA = 2'd1,
      TGT_TASK = 2'd2,
      TGT_CTRL = 2'd3
   } tgt_e;

   localparam logic [3:0] PORT_DATA = 4'd0;
   localparam logic [3:0] PORT_CTRL = 4'd8;
   localparam int         TASK_LO   = 1;
   localparam int         TASK_HI   = 7;

endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
   import ide_bridge_pkg::*;
#(
   parameter int WIN_BITS    = 12,
   parameter int STRIDE_BITS = 4,
   parameter int CTL_IDX_A   = 8,
   parameter int CTL_IDX_B   = 22
) (
   input  logic [WIN_BITS-1:0] win_addr,
   input  logic [1:0]          size,
   output tgt_e                tgt,
   output logic [3:0]          port
);
   localparam int IDX_W = WIN_BITS - STRIDE_BITS;

   if (IDX_W < 5) begin : g_bad_idx
      $error("window/stride leave too few index bits");
   end
   if (CTL_IDX_A <= TASK_HI || CTL_IDX_B <= TASK_HI ||
       CTL_IDX_A >= (1 << IDX_W) || CTL_IDX_B >= (1 << IDX_W)) begin : g_bad_ctl
      $error("control aliases must lie above the task file and inside the window");
   end

   logic [IDX_W-1:0] idx;
   logic             is_task, is_ctrl, is_zero;
   logic [STRIDE_BITS-1:0] unused_stride_bits;

   assign idx                = win_addr[WIN_BITS-1:STRIDE_BITS];
   assign unused_stride_bits = win_addr[STRIDE_BITS-1:0];
   assign is_task = (idx >= IDX_W'(TASK_LO)) && (idx <= IDX_W'(TASK_HI));
   assign is_ctrl = (idx == IDX_W'(CTL_IDX_A)) || (idx == IDX_W'(CTL_IDX_B));
   assign is_zero = (idx == '0);

   always_comb begin
      tgt  = TGT_NONE;
      port = PORT_DATA;
      unique case (acc_size_e'(size))
         SZ_BYTE: begin
            if (is_task) begin
               tgt  = TGT_TASK;
               port = idx[3:0];
            end else if (is_ctrl) begin
               tgt  = TGT_CTRL;
               port = PORT_CTRL;
            end
         end
         SZ_HALF, SZ_WORD: begin
            if (is_zero) tgt = TGT_DATA;
         end
         default: tgt = TGT_NONE;
      endcase
   end
endmodule

// File: rtl/ide_lane_swap.sv
module ide_lane_swap #(
   parameter int LANES   = 4,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic [8*LANES-1:0] din,
   output logic [8*LANES-1:0] dout
);
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least one");
   end

   if (SWAP_EN) begin : g_swap
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign dout[8*i +: 8] = din[8*(LANES-1-i) +: 8];
      end
   end else begin : g_pass
      assign dout = din;
   end
endmodule

// File: rtl/ide_rsp_stage.sv
module ide_rsp_stage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] cap_data,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_rdata <= cap_data;
      end
   end

   // one pulse per read, one cycle after it
   assert_rsp_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> rsp_valid);
   assert_rsp_only_for_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> !rsp_valid);
   assert_rsp_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(rsp_rdata));
endmodule

// File: rtl/ide_mmio_bridge.sv
module ide_mmio_bridge
   import ide_bridge_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int WIN_BITS    = 12,
   parameter int STRIDE_BITS = 4,
   parameter int CTL_IDX_A   = 8,
   parameter int CTL_IDX_B   = 22,
   parameter bit HOST_BIG_ENDIAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              reg_strobe,
   output logic              reg_write,
   output logic [3:0]        reg_index,
   output logic [1:0]        reg_size,
   output logic [31:0]       reg_wdata,
   input  logic [31:0]       reg_rdata
);
   localparam int DATA_W = 32;

   if (ADDR_W < WIN_BITS) begin : g_bad_addr
      $error("address narrower than the register window");
   end

   tgt_e        tgt;
   logic [3:0]  port;
   logic [15:0] w16_sw, r16_sw;
   logic [31:0] w32_sw, r32_sw;
   logic [31:0] rd_mux;
   logic        is_read;

   if (ADDR_W > WIN_BITS) begin : g_upper
      logic unused_upper_addr;
      assign unused_upper_addr = ^req_addr[ADDR_W-1:WIN_BITS];
   end

   ide_win_decode #(
      .WIN_BITS(WIN_BITS), .STRIDE_BITS(STRIDE_BITS),
      .CTL_IDX_A(CTL_IDX_A), .CTL_IDX_B(CTL_IDX_B)
   ) u_dec (
      .win_addr(req_addr[WIN_BITS-1:0]),
      .size    (req_size),
      .tgt     (tgt),
      .port    (port)
   );

   ide_lane_swap #(.LANES(2), .SWAP_EN(HOST_BIG_ENDIAN)) u_sw16_w
      (.din(req_wdata[15:0]), .dout(w16_sw));
   ide_lane_swap #(.LANES(4), .SWAP_EN(HOST_BIG_ENDIAN)) u_sw32_w
      (.din(req_wdata),       .dout(w32_sw));
   ide_lane_swap #(.LANES(2), .SWAP_EN(HOST_BIG_ENDIAN)) u_sw16_r
      (.din(reg_rdata[15:0]), .dout(r16_sw));
   ide_lane_swap #(.LANES(4), .SWAP_EN(HOST_BIG_ENDIAN)) u_sw32_r
      (.din(reg_rdata),       .dout(r32_sw));

   assign reg_strobe = req_valid && (tgt != TGT_NONE);
   assign reg_write  = req_write;
   assign reg_index  = port;
   assign reg_size   = req_size;
   assign is_read    = req_valid && !req_write;

   always_comb begin
      unique case (acc_size_e'(req_size))
         SZ_BYTE: reg_wdata = {24'h0, req_wdata[7:0]};
         SZ_HALF: reg_wdata = {16'h0, w16_sw};
         default: reg_wdata = w32_sw;
      endcase
   end

   always_comb begin
      if (tgt == TGT_NONE) begin
         unique case (acc_size_e'(req_size))
            SZ_BYTE: rd_mux = 32'h0000_00FF;
            SZ_HALF: rd_mux = 32'h0000_FFFF;
            default: rd_mux = 32'hFFFF_FFFF;
         endcase
      end else begin
         unique case (acc_size_e'(req_size))
            SZ_BYTE: rd_mux = {24'h0, reg_rdata[7:0]};
            SZ_HALF: rd_mux = {16'h0, r16_sw};
            default: rd_mux = r32_sw;
         endcase
      end
   end

   ide_rsp_stage #(.DATA_W(DATA_W)) u_rsp (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (is_read),
      .cap_data (rd_mux),
      .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata)
   );

   assert_data_port_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_strobe && reg_index == PORT_DATA) |-> (req_size == SZ_HALF || req_size == SZ_WORD));
   assert_index_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_strobe |-> (reg_index <= PORT_CTRL));
   assert_byte_unmapped_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_read && !reg_strobe && req_size == SZ_BYTE) |=> (rsp_rdata == 32'h0000_00FF));
   assert_wide_unmapped_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_read && !reg_strobe && req_size == SZ_WORD) |=> (rsp_rdata == 32'hFFFF_FFFF));
   assert_no_strobe_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !reg_strobe);
endmodule

// File: tb/ide_mmio_bridge_test.sv
module ide_mmio_bridge_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        rsp_valid, reg_strobe, reg_write;
   logic [31:0] rsp_rdata, reg_wdata, reg_rdata;
   logic [3:0]  reg_index;
   logic [1:0]  reg_size;

   int checks = 0, fails = 0, cycles = 0;
   bit done = 1'b0;

   typedef struct {
      bit          want_rsp;
      logic [31:0] data;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   ide_mmio_bridge uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .reg_strobe(reg_strobe),
      .reg_write(reg_write), .reg_index(reg_index), .reg_size(reg_size),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   // drive model: each port returns its own pattern
   assign reg_rdata = 32'h1A2B3C4D + {4'h0, reg_index, 4'h0, reg_index, 4'h0, reg_index, 4'h0, reg_index};

   function automatic logic [31:0] model_rd(input logic [3:0] p);
      return 32'h1A2B3C4D + {4'h0, p, 4'h0, p, 4'h0, p, 4'h0, p};
   endfunction
   function automatic logic [31:0] sw16(input logic [31:0] x);
      return {16'h0, x[7:0], x[15:8]};
   endfunction
   function automatic logic [31:0] rev32(input logic [31:0] x);
      return {x[7:0], x[15:8], x[23:16], x[31:24]};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: one request per cycle, downstream checked in the request cycle
   task automatic access(input bit wr, input logic [1:0] sz, input logic [31:0] addr,
                         input logic [31:0] wd, input bit exp_stb, input logic [3:0] exp_idx,
                         input logic [31:0] exp_val, input string tag);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
      #2;
      check(reg_strobe == exp_stb, {tag, " strobe"}, {31'h0, reg_strobe}, {31'h0, exp_stb});
      if (exp_stb) begin
         check(reg_index == exp_idx && reg_write == wr && reg_size == sz,
               {tag, " index"}, {28'h0, reg_index}, {28'h0, exp_idx});
         if (wr) check(reg_wdata == exp_val, {tag, " wdata"}, reg_wdata, exp_val);
      end
      e.want_rsp = !wr;
      e.data     = exp_val;
      e.tag      = tag;
      sb.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: between edges, pops one expectation per request
   always @(posedge clk) begin
      #5;
      if (rst_n && !done) begin
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            if (e.want_rsp) begin
               check(rsp_valid == 1'b1, {e.tag, " R8 rsp_valid"}, {31'h0, rsp_valid}, 32'h1);
               check(rsp_rdata == e.data, {e.tag, " rdata"}, rsp_rdata, e.data);
            end else begin
               check(rsp_valid == 1'b0, {e.tag, " R8 no rsp on write"}, {31'h0, rsp_valid}, 32'h0);
            end
         end else if (rsp_valid) begin
            check(1'b0, "R8 unrequested rsp_valid", 32'h1, 32'h0);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         fails++; checks++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      // R9 reset state
      check(rsp_valid == 1'b0, "R9 rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
      check(rsp_rdata == 32'h0, "R9 rsp_rdata in reset", rsp_rdata, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      // R2 task file, R1 low nibble and upper bits ignored
      access(1'b0, 2'd0, 32'h0000_0010, '0, 1'b1, 4'd1, {24'h0, model_rd(4'd1)[7:0]}, "R2 rd idx1");
      access(1'b0, 2'd0, 32'hABCD_E07C, '0, 1'b1, 4'd7, {24'h0, model_rd(4'd7)[7:0]}, "R1 rd idx7 aliased");
      access(1'b1, 2'd0, 32'h0000_1035, 32'hDEAD_BE5A, 1'b1, 4'd3, 32'h0000_005A, "R1 R2 wr idx3");
      // R3 both control aliases
      access(1'b1, 2'd0, 32'h0000_0080, 32'h0000_0006, 1'b1, 4'd8, 32'h0000_0006, "R3 wr ctl idx8");
      access(1'b0, 2'd0, 32'h0000_0160, '0, 1'b1, 4'd8, {24'h0, model_rd(4'd8)[7:0]}, "R3 rd alt idx22");
      access(1'b0, 2'd0, 32'h0000_0083, '0, 1'b1, 4'd8, {24'h0, model_rd(4'd8)[7:0]}, "R3 rd alt idx8");
      // R4 unmapped bytes, index 0 included
      access(1'b0, 2'd0, 32'h0000_0000, '0, 1'b0, 4'd0, 32'h0000_00FF, "R4 rd byte idx0");
      access(1'b0, 2'd0, 32'h0000_0F00, '0, 1'b0, 4'd0, 32'h0000_00FF, "R4 rd byte idx240");
      access(1'b1, 2'd0, 32'h0000_0090, 32'h55, 1'b0, 4'd0, 32'h0, "R4 wr byte idx9");
      // R5 half at data
      access(1'b1, 2'd1, 32'h0000_0000, 32'h0000_1234, 1'b1, 4'd0, 32'h0000_3412, "R5 wr half");
      access(1'b0, 2'd1, 32'h0000_0002, '0, 1'b1, 4'd0, sw16(model_rd(4'd0)), "R5 rd half");
      // R6 word at data
      access(1'b1, 2'd2, 32'h0000_0000, 32'h0102_0304, 1'b1, 4'd0, 32'h0403_0201, "R6 wr word");
      access(1'b0, 2'd2, 32'h5000_0004, '0, 1'b1, 4'd0, rev32(model_rd(4'd0)), "R6 rd word");
      // R7 wide elsewhere, reserved size
      access(1'b0, 2'd1, 32'h0000_0010, '0, 1'b0, 4'd0, 32'h0000_FFFF, "R7 rd half idx1");
      access(1'b0, 2'd2, 32'h0000_0080, '0, 1'b0, 4'd0, 32'hFFFF_FFFF, "R7 rd word idx8");
      access(1'b1, 2'd2, 32'h0000_0020, 32'hCAFE_F00D, 1'b0, 4'd0, 32'h0, "R7 wr word idx2");
      access(1'b0, 2'd3, 32'h0000_0000, '0, 1'b0, 4'd0, 32'hFFFF_FFFF, "R7 rd rsvd size");
      idle();
      repeat (2) @(negedge clk);
      // R8 idle: no stray pulse
      check(rsp_valid == 1'b0, "R8 idle no rsp", {31'h0, rsp_valid}, 32'h0);
      access(1'b0, 2'd0, 32'h0000_0050, '0, 1'b1, 4'd5, {24'h0, model_rd(4'd5)[7:0]}, "R2 rd idx5 after idle");
      idle();
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule